// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of a 1-Kbit serial EEPROM. It sits behind a three-wire interface: a chip select, a shift clock and a serial data input, plus a serial data output with a separate output-enable, so the output can be tri-stated. A system clock oversamples all three inputs and acts on each detected rising edge of the shift clock. An organization input chooses between 128 locations of 8 bits and 64 locations of 16 bits. Both views share one byte array that resets to all ones.

The host starts every instruction by raising chip select and shifting in a 1 as the start bit. A two-bit opcode and an address follow. For writes, the data word comes after the address. Reads return a dummy zero and then the addressed word, most significant bit first. Programming instructions run only while a write-enable latch is set, and they start a self-timed busy period of a parameterized length. A host that drops chip select and raises it again can then poll ready/busy on the data output. Erase-all and write-all also need the high-supply-ok input to be asserted.

Top module: `sep_eeprom`

## Requirements
- R1: After reset the output enable is low, the enable latch is clear and every array bit reads as 1.
- R2: While chip select is high, 0 bits ahead of the first 1 are ignored. After that start bit come a 2-bit opcode and then the address, 7 bits when `org_word`=0 or 6 bits when `org_word`=1, all taken MSB first on rising shift-clock edges.
- R3: Opcode 10 reads. On the rising edge that samples the last address bit, the output is enabled and drives a 0 dummy bit. Each following rising edge drives the next data bit, MSB first. A read works whether the latch is set or clear. In word mode, word w is byte 2w in its upper half and byte 2w+1 in its lower half.
- R4: Opcode 00 is extended by the top two address bits. Bits 11 set the enable latch and bits 00 clear it. While the latch is clear, every programming instruction leaves the array unchanged.
- R5: Opcode 01 followed by a full data word (8 or 16 bits, MSB first) writes that word to the addressed location, with no prior erase needed.
- R6: Opcode 11 sets every bit of the addressed location to 1 and leaves other locations unchanged.
- R7: Extended code 10 sets the whole array to ones. Extended code 01, followed by a data word, writes that word to every location. Both take effect only if `supply_ok`=1 and the latch is set.
- R8: An accepted programming instruction starts a busy period of PROG_CYCLES system clocks on its last bit. A start bit that arrives while busy makes the rest of that instruction ignored.
- R9: The output is disabled while chip select is low. After a programming instruction, raising chip select again enables the output, which shows 0 while busy and 1 when ready. The next accepted start bit disables it again.
- R10: An instruction cut short by chip select falling is discarded and changes neither the array nor the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial shift clock |
| di | input | 1 | Serial data in |
| org_word | input | 1 | 1 selects 64 x 16, 0 selects 128 x 8 |
| supply_ok | input | 1 | High-supply-ok qualifier for the bulk instructions |
| do_out | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for `do_out` (0 means high impedance) |

## Verification
The bench writes every byte location with a different pattern and reads them all back. It then reads all 64 words in word mode. A design that swapped the halves of a word, used the wrong address width, or dropped the dummy bit would misplace a data bit or a whole byte. The bench sends programming instructions while the latch is clear, bulk instructions with the supply qualifier low, a second write started during the busy period, and instructions cut short by chip select. A design that ignored the guard or the abort would change a location the bench expects to keep. Ready/busy is sampled well before and well after the expected end of the busy period, and once more after the next start bit. This catches a timer that is too short or never stops, and a status indication that is never cleared.

// File: rtl/sep_pkg.sv
package sep_pkg;

   typedef enum logic [1:0] {
      OP_EXT   = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_ERASE = 2'b11
   } opcode_e;

   typedef enum logic [1:0] {
      EX_LOCK   = 2'b00,
      EX_FILL   = 2'b01,
      EX_WIPE   = 2'b10,
      EX_UNLOCK = 2'b11
   } ext_e;

   typedef enum logic [1:0] {
      PG_WORD,
      PG_CLEAR,
      PG_FILL,
      PG_WIPE
   } prog_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADDR,
      ST_DATA,
      ST_SEND,
      ST_HOLD
   } frame_e;

endpackage

// File: rtl/sep_sync.sv
module sep_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sep_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sep_frame.sv
module sep_frame
   import sep_pkg::*;
#(
   parameter int BYTE_AW = 7,
   parameter int BYTE_W  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_s,
   input  logic                 sk_rise,
   input  logic                 di_s,
   input  logic                 org_word,
   input  logic                 supply_ok,
   input  logic                 busy,
   input  logic [2*BYTE_W-1:0]  rd_word,
   output logic [BYTE_AW-1:0]   rd_addr,
   output logic                 prog_go,
   output prog_e                prog_kind,
   output logic [BYTE_AW-1:0]   prog_addr,
   output logic [2*BYTE_W-1:0]  prog_data,
   output logic                 wen,
   output logic                 do_out,
   output logic                 do_oe
);

   localparam int WORD_W = 2 * BYTE_W;
   localparam int MAXB   = (WORD_W > BYTE_AW) ? WORD_W : BYTE_AW;
   localparam int CW     = $clog2(MAXB + 1);

   frame_e              st_q;
   logic [1:0]          op_q;
   logic [BYTE_AW-1:0]  addr_q;
   logic [WORD_W-1:0]   data_q;
   logic [WORD_W-1:0]   out_q;
   logic [CW-1:0]       cnt_q;
   logic                wen_q;
   logic                pend_q;
   logic                armed_q;
   logic                dout_q;

   logic [CW-1:0]       aw_last;
   logic [CW-1:0]       dw_last;
   logic [BYTE_AW-1:0]  addr_full;
   logic [WORD_W-1:0]   data_full;
   logic [1:0]          ext_bits;
   logic                addr_done;
   logic                data_done;

   assign aw_last   = org_word ? CW'(BYTE_AW - 2) : CW'(BYTE_AW - 1);
   assign dw_last   = org_word ? CW'(WORD_W - 1)  : CW'(BYTE_W - 1);
   assign addr_full = {addr_q[BYTE_AW-2:0], di_s};
   assign data_full = {data_q[WORD_W-2:0], di_s};
   assign ext_bits  = org_word ? addr_full[BYTE_AW-2 -: 2] : addr_full[BYTE_AW-1 -: 2];
   assign addr_done = sk_rise && cs_s && (st_q == ST_ADDR) && (cnt_q == aw_last);
   assign data_done = sk_rise && cs_s && (st_q == ST_DATA) && (cnt_q == dw_last);

   // program request: raised on the edge that carries the final bit
   always_comb begin
      prog_go   = 1'b0;
      prog_kind = PG_WORD;
      if (addr_done) begin
         if (op_q == OP_ERASE) begin
            prog_go   = wen_q;
            prog_kind = PG_CLEAR;
         end else if (op_q == OP_EXT && ext_bits == EX_WIPE) begin
            prog_go   = wen_q && supply_ok;
            prog_kind = PG_WIPE;
         end
      end else if (data_done) begin
         if (op_q == OP_EXT) begin
            prog_go   = wen_q && supply_ok;
            prog_kind = PG_FILL;
         end else begin
            prog_go   = wen_q;
            prog_kind = PG_WORD;
         end
      end
   end

   assign rd_addr   = addr_full;
   assign prog_addr = (st_q == ST_DATA) ? addr_q : addr_full;
   assign prog_data = org_word ? data_full : {{BYTE_W{1'b0}}, data_full[BYTE_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         op_q    <= '0;
         addr_q  <= '0;
         data_q  <= '0;
         out_q   <= '0;
         cnt_q   <= '0;
         wen_q   <= 1'b0;
         pend_q  <= 1'b0;
         armed_q <= 1'b0;
         dout_q  <= 1'b0;
      end else begin
         if (!cs_s) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            if (pend_q) armed_q <= 1'b1;
         end else if (sk_rise) begin
            unique case (st_q)
               ST_IDLE: begin
                  if (di_s) begin
                     if (busy) begin
                        st_q <= ST_HOLD;
                     end else begin
                        st_q    <= ST_OPC;
                        cnt_q   <= '0;
                        op_q    <= '0;
                        addr_q  <= '0;
                        data_q  <= '0;
                        pend_q  <= 1'b0;
                        armed_q <= 1'b0;
                     end
                  end
               end
               ST_OPC: begin
                  op_q <= {op_q[0], di_s};
                  if (cnt_q == CW'(1)) begin
                     st_q  <= ST_ADDR;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_ADDR: begin
                  addr_q <= addr_full;
                  if (cnt_q == aw_last) begin
                     cnt_q <= '0;
                     unique case (op_q)
                        OP_READ: begin
                           st_q   <= ST_SEND;
                           out_q  <= rd_word;
                           dout_q <= 1'b0;
                        end
                        OP_WRITE: st_q <= ST_DATA;
                        OP_ERASE: st_q <= ST_HOLD;
                        default: begin
                           unique case (ext_bits)
                              EX_UNLOCK: begin wen_q <= 1'b1; st_q <= ST_HOLD; end
                              EX_LOCK:   begin wen_q <= 1'b0; st_q <= ST_HOLD; end
                              EX_FILL:   st_q <= ST_DATA;
                              default:   st_q <= ST_HOLD;
                           endcase
                        end
                     endcase
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_DATA: begin
                  data_q <= data_full;
                  if (cnt_q == dw_last) st_q <= ST_HOLD;
                  else                  cnt_q <= cnt_q + 1'b1;
               end
               ST_SEND: begin
                  if (cnt_q <= dw_last) begin
                     dout_q <= out_q[WORD_W-1];
                     out_q  <= {out_q[WORD_W-2:0], 1'b0};
                     cnt_q  <= cnt_q + 1'b1;
                  end else begin
                     st_q   <= ST_HOLD;
                     dout_q <= 1'b0;
                  end
               end
               default: ;
            endcase
         end
         if (prog_go) pend_q <= 1'b1;
      end
   end

   assign wen    = wen_q;
   assign do_oe  = cs_s && ((st_q == ST_SEND) || (pend_q && armed_q));
   assign do_out = (st_q == ST_SEND) ? dout_q : ~busy;

endmodule

// File: rtl/sep_store.sv
module sep_store
   import sep_pkg::*;
#(
   parameter int BYTE_AW     = 7,
   parameter int BYTE_W      = 8,
   parameter int PROG_CYCLES = 1250000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 org_word,
   input  logic [BYTE_AW-1:0]   rd_addr,
   output logic [2*BYTE_W-1:0]  rd_word,
   input  logic                 prog_go,
   input  prog_e                prog_kind,
   input  logic [BYTE_AW-1:0]   prog_addr,
   input  logic [2*BYTE_W-1:0]  prog_data,
   output logic                 busy
);

   localparam int DEPTH   = 1 << BYTE_AW;
   localparam int WORD_AW = BYTE_AW - 1;
   localparam int WORD_W  = 2 * BYTE_W;
   localparam int TW      = $clog2(PROG_CYCLES + 1);

   logic [DEPTH-1:0][BYTE_W-1:0] cells;
   logic bulk;
   logic blank;

   assign bulk  = (prog_kind == PG_FILL) || (prog_kind == PG_WIPE);
   assign blank = (prog_kind == PG_CLEAR) || (prog_kind == PG_WIPE);

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      localparam logic [BYTE_AW-1:0] IDX = BYTE_AW'(g);
      logic              hit;
      logic [BYTE_W-1:0] nv;
      logic [BYTE_W-1:0] cell_q;

      always_comb begin
         if (bulk)          hit = 1'b1;
         else if (org_word) hit = (IDX[BYTE_AW-1:1] == prog_addr[WORD_AW-1:0]);
         else               hit = (IDX == prog_addr);
         if (blank)         nv = '1;
         else if (!org_word) nv = prog_data[BYTE_W-1:0];
         else if (IDX[0])   nv = prog_data[BYTE_W-1:0];
         else               nv = prog_data[WORD_W-1:BYTE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             cell_q <= '1;
         else if (prog_go && hit) cell_q <= nv;
      end

      assign cells[g] = cell_q;
   end

   assign rd_word = org_word
      ? {cells[{rd_addr[WORD_AW-1:0], 1'b0}], cells[{rd_addr[WORD_AW-1:0], 1'b1}]}
      : {cells[rd_addr], {BYTE_W{1'b0}}};

   logic [TW-1:0] tmr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            tmr_q <= '0;
      else if (prog_go)      tmr_q <= TW'(PROG_CYCLES);
      else if (tmr_q != '0)  tmr_q <= tmr_q - 1'b1;
   end

   assign busy = (tmr_q != '0);

endmodule

// File: rtl/sep_eeprom.sv
module sep_eeprom
   import sep_pkg::*;
#(
   parameter int BYTE_AW     = 7,
   parameter int BYTE_W      = 8,
   parameter int PROG_CYCLES = 1250000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sk,
   input  logic di,
   input  logic org_word,
   input  logic supply_ok,
   output logic do_out,
   output logic do_oe
);

   localparam int WORD_W = 2 * BYTE_W;

   if (BYTE_AW < 3) begin : g_bad_aw
      $error("sep_eeprom: BYTE_AW must be at least 3");
   end
   if (BYTE_W < 2) begin : g_bad_w
      $error("sep_eeprom: BYTE_W must be at least 2");
   end
   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("sep_eeprom: PROG_CYCLES must be at least 1");
   end

   logic [2:0] pins_s;
   logic       cs_s, sk_s, di_s, sk_d, sk_rise;

   sep_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs, sk, di}), .q(pins_s)
   );

   assign {cs_s, sk_s, di_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sk_d <= 1'b0;
      else        sk_d <= sk_s;
   end

   assign sk_rise = sk_s && !sk_d;

   logic [WORD_W-1:0]  rd_word;
   logic [BYTE_AW-1:0] rd_addr;
   logic               prog_go;
   prog_e              prog_kind;
   logic [BYTE_AW-1:0] prog_addr;
   logic [WORD_W-1:0]  prog_data;
   logic               busy;
   logic               wen;

   sep_frame #(.BYTE_AW(BYTE_AW), .BYTE_W(BYTE_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sk_rise(sk_rise), .di_s(di_s),
      .org_word(org_word), .supply_ok(supply_ok), .busy(busy),
      .rd_word(rd_word), .rd_addr(rd_addr),
      .prog_go(prog_go), .prog_kind(prog_kind), .prog_addr(prog_addr),
      .prog_data(prog_data), .wen(wen), .do_out(do_out), .do_oe(do_oe)
   );

   sep_store #(.BYTE_AW(BYTE_AW), .BYTE_W(BYTE_W), .PROG_CYCLES(PROG_CYCLES)) u_store (
      .clk(clk), .rst_n(rst_n), .org_word(org_word),
      .rd_addr(rd_addr), .rd_word(rd_word),
      .prog_go(prog_go), .prog_kind(prog_kind), .prog_addr(prog_addr),
      .prog_data(prog_data), .busy(busy)
   );

endmodule

// File: rtl/sep_checker.sv
module sep_checker
   import sep_pkg::*;
(
   input logic  clk,
   input logic  rst_n,
   input logic  cs,
   input logic  cs_s,
   input logic  sk_rise,
   input logic  supply_ok,
   input logic  busy,
   input logic  wen,
   input logic  prog_go,
   input prog_e prog_kind,
   input logic  do_oe
);

   // R9: a chip select held low for three cycles leaves the output released
   assert_float_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs && !$past(cs) && !$past(cs, 2)) |-> !do_oe);

   // R4: nothing is programmed while the enable latch is clear
   assert_locked_no_prog_R4: assert property (@(posedge clk) disable iff (!rst_n)
      prog_go |-> wen);

   // R8: an accepted program request makes the part busy on the next cycle
   assert_busy_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      prog_go |=> busy);

   // R8: no second program request while a cycle is running
   assert_no_go_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !prog_go);

   // R7: bulk requests only with the supply qualifier high
   assert_bulk_supply_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_go && (prog_kind == PG_FILL || prog_kind == PG_WIPE)) |-> supply_ok);

   // R2: program requests only come on a shift edge inside a selected frame
   assert_go_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      prog_go |-> (sk_rise && cs_s));

endmodule

bind sep_eeprom sep_checker u_chk (
   .clk(clk), .rst_n(rst_n), .cs(cs), .cs_s(cs_s), .sk_rise(sk_rise),
   .supply_ok(supply_ok), .busy(busy), .wen(wen), .prog_go(prog_go),
   .prog_kind(prog_kind), .do_oe(do_oe)
);

// File: tb/sep_eeprom_test.sv
`timescale 1ns/1ps
module sep_eeprom_test;

   localparam int PROG = 60;
   localparam int H    = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sk = 1'b0, di = 1'b0;
   logic org_word = 1'b0, supply_ok = 1'b0;
   logic do_out, do_oe;

   always #2 clk = ~clk;

   sep_eeprom #(.BYTE_AW(7), .BYTE_W(8), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
      .org_word(org_word), .supply_ok(supply_ok), .do_out(do_out), .do_oe(do_oe)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int t_rise = 0;
   bit done = 1'b0;
   logic smp_o, smp_e;
   logic [7:0] model [128];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int aw();
      return org_word ? 6 : 7;
   endfunction

   function automatic int dw();
      return org_word ? 16 : 8;
   endfunction

   function automatic logic [6:0] xa(input logic [1:0] c);
      return org_word ? {1'b0, c, 4'b0} : {c, 5'b0};
   endfunction

   task automatic pulse(input logic b);
      di = b;
      idle(H);
      sk = 1'b1;
      t_rise = cyc;
      idle(H);
      sk = 1'b0;
      smp_o = do_out;
      smp_e = do_oe;
   endtask

   task automatic end_frame();
      cs = 1'b0;
      di = 1'b0;
      idle(2 * H);
   endtask

   // start bit, opcode, address and optional data; chip select left high
   task automatic frame(input logic [1:0] op, input logic [6:0] a,
                        input logic [15:0] d, input bit with_data);
      cs = 1'b1;
      idle(H);
      pulse(1'b1);
      pulse(op[1]);
      pulse(op[0]);
      for (int i = aw() - 1; i >= 0; i--) pulse(a[i]);
      if (with_data)
         for (int i = dw() - 1; i >= 0; i--) pulse(d[i]);
   endtask

   task automatic wait_ready(input string tag);
      bit seen;
      seen = 1'b0;
      cs = 1'b0;
      idle(H);
      cs = 1'b1;
      for (int i = 0; i < 400 && !seen; i++) begin
         @(negedge clk);
         if (do_oe === 1'b1 && do_out === 1'b1) seen = 1'b1;
      end
      expect_eq(tag, {31'b0, seen}, 32'd1);
      end_frame();
   endtask

   task automatic rd(input logic [6:0] a, output logic [15:0] w,
                     output logic dm, output logic dme);
      w = '0;
      cs = 1'b1;
      idle(H);
      pulse(1'b1);
      pulse(1'b1);
      pulse(1'b0);
      for (int i = aw() - 1; i >= 1; i--) pulse(a[i]);
      pulse(a[0]);
      dm  = smp_o;
      dme = smp_e;
      for (int i = 0; i < dw(); i++) begin
         pulse(1'b0);
         w = {w[14:0], smp_o};
      end
      end_frame();
   endtask

   task automatic read_chk(input logic [6:0] a, input logic [15:0] exp, input string tag);
      logic [15:0] w;
      logic dm, dme;
      rd(a, w, dm, dme);
      expect_eq(tag, {16'b0, w}, {16'b0, exp});
   endtask

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 11) & 255);
   endfunction

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] w;
      logic dm, dme;
      for (int i = 0; i < 128; i++) model[i] = 8'hFF;
      idle(4);
      rst_n = 1'b1;
      idle(4);

      // R1 reset state
      expect_eq("R1 output enable after reset", {31'b0, do_oe}, 32'd0);
      rd(7'd0, w, dm, dme);
      expect_eq("R1 location 0 after reset", {16'b0, w}, 32'hFF);
      expect_eq("R3 dummy bit value", {31'b0, dm}, 32'd0);
      expect_eq("R3 dummy bit driven", {31'b0, dme}, 32'd1);
      read_chk(7'd127, 16'hFF, "R1 location 127 after reset");

      // R4 write with latch clear is ignored
      frame(2'b01, 7'd5, 16'h003C, 1'b1);
      end_frame();
      idle(2 * PROG);
      read_chk(7'd5, 16'hFF, "R4 write while locked");

      // R2 leading zeros, then unlock
      cs = 1'b1;
      idle(H);
      pulse(1'b0);
      pulse(1'b0);
      pulse(1'b1);
      pulse(1'b0);
      pulse(1'b0);
      for (int i = 6; i >= 0; i--) pulse(xa(2'b11)[i]);
      end_frame();

      // R8/R9 status timing around one write
      frame(2'b01, 7'h10, 16'h00A5, 1'b1);
      model[16] = 8'hA5;
      begin
         int t0;
         t0 = t_rise;
         cs = 1'b0;
         idle(H);
         expect_eq("R9 output released with chip select low", {31'b0, do_oe}, 32'd0);
         cs = 1'b1;
         while (cyc < t0 + PROG - 15) @(negedge clk);
         expect_eq("R9 status enabled while busy", {31'b0, do_oe}, 32'd1);
         expect_eq("R8 busy shown before period ends", {31'b0, do_out}, 32'd0);
         while (cyc < t0 + PROG + 15) @(negedge clk);
         expect_eq("R9 ready shown after period ends", {31'b0, do_out}, 32'd1);
         pulse(1'b1);
         expect_eq("R9 status cleared by start bit", {31'b0, smp_e}, 32'd0);
         end_frame();
      end
      read_chk(7'h10, 16'hA5, "R5 write 0x10 after status poll");

      // R5 byte sweep
      for (int a = 0; a < 128; a++) begin
         frame(2'b01, 7'(a), {8'h00, pat(a)}, 1'b1);
         wait_ready("R8 ready after byte write");
         model[a] = pat(a);
      end
      for (int a = 0; a < 128; a++) read_chk(7'(a), {8'h00, model[a]}, "R5 byte sweep readback");

      // R3 word-mode sweep
      org_word = 1'b1;
      rd(7'd0, w, dm, dme);
      expect_eq("R3 word dummy bit", {31'b0, dm}, 32'd0);
      for (int wa = 0; wa < 64; wa++)
         read_chk(7'(wa), {model[2*wa], model[2*wa+1]}, "R3 word sweep readback");

      // R5 word write, R3 byte mapping
      frame(2'b01, 7'd9, 16'hBEEF, 1'b1);
      wait_ready("R8 ready after word write");
      model[18] = 8'hBE;
      model[19] = 8'hEF;
      read_chk(7'd9, 16'hBEEF, "R5 word write readback");
      org_word = 1'b0;
      read_chk(7'd18, 16'hBE, "R3 upper half in even byte");
      read_chk(7'd19, 16'hEF, "R3 lower half in odd byte");

      // R6 erase
      frame(2'b11, 7'd18, 16'h0, 1'b0);
      wait_ready("R8 ready after erase");
      model[18] = 8'hFF;
      read_chk(7'd18, 16'hFF, "R6 byte erase");
      read_chk(7'd19, 16'hEF, "R6 neighbour kept");
      org_word = 1'b1;
      frame(2'b11, 7'd3, 16'h0, 1'b0);
      wait_ready("R8 ready after word erase");
      model[6] = 8'hFF;
      model[7] = 8'hFF;
      read_chk(7'd3, 16'hFFFF, "R6 word erase");
      org_word = 1'b0;

      // R8 instruction started while busy is ignored
      frame(2'b01, 7'd40, 16'h0011, 1'b1);
      end_frame();
      frame(2'b01, 7'd41, 16'h0022, 1'b1);
      end_frame();
      idle(2 * PROG);
      model[40] = 8'h11;
      read_chk(7'd40, 16'h11, "R8 first write lands");
      read_chk(7'd41, {8'h00, model[41]}, "R8 write during busy ignored");

      // R10 aborted write and aborted lock
      cs = 1'b1;
      idle(H);
      pulse(1'b1); pulse(1'b0); pulse(1'b1);
      for (int i = 6; i >= 0; i--) pulse(7'(50) >> i);
      pulse(1'b0); pulse(1'b0); pulse(1'b0);
      end_frame();
      idle(2 * PROG);
      read_chk(7'd50, {8'h00, model[50]}, "R10 aborted write discarded");
      cs = 1'b1;
      idle(H);
      pulse(1'b1); pulse(1'b0); pulse(1'b0); pulse(1'b0); pulse(1'b0);
      end_frame();
      frame(2'b01, 7'd51, 16'h0077, 1'b1);
      wait_ready("R10 ready after write following aborted lock");
      model[51] = 8'h77;
      read_chk(7'd51, 16'h77, "R10 aborted lock left latch set");

      // R7 bulk instructions gated by supply
      supply_ok = 1'b0;
      frame(2'b00, xa(2'b10), 16'h0, 1'b0);
      end_frame();
      idle(2 * PROG);
      frame(2'b00, xa(2'b01), 16'h0000, 1'b1);
      end_frame();
      idle(2 * PROG);
      read_chk(7'd0, {8'h00, model[0]}, "R7 bulk ignored with supply low");
      read_chk(7'd100, {8'h00, model[100]}, "R7 bulk ignored with supply low");
      supply_ok = 1'b1;
      frame(2'b00, xa(2'b01), 16'h005A, 1'b1);
      wait_ready("R8 ready after write-all");
      for (int a = 0; a < 128; a++) model[a] = 8'h5A;
      for (int a = 0; a < 128; a++) read_chk(7'(a), 16'h5A, "R7 write-all sweep");
      frame(2'b00, xa(2'b10), 16'h0, 1'b0);
      wait_ready("R8 ready after erase-all");
      for (int a = 0; a < 128; a++) model[a] = 8'hFF;
      read_chk(7'd0, 16'hFF, "R7 erase-all low end");
      read_chk(7'd127, 16'hFF, "R7 erase-all high end");
      org_word = 1'b1;
      frame(2'b00, xa(2'b01), 16'h1234, 1'b1);
      wait_ready("R8 ready after word write-all");
      read_chk(7'd7, 16'h1234, "R7 word write-all");
      org_word = 1'b0;
      read_chk(7'd15, 16'h34, "R7 word write-all lower byte");
      for (int a = 0; a < 128; a++) model[a] = a[0] ? 8'h34 : 8'h12;

      // R4 lock then write ignored; read still works
      frame(2'b00, xa(2'b00), 16'h0, 1'b0);
      end_frame();
      frame(2'b01, 7'd3, 16'h0000, 1'b1);
      end_frame();
      idle(2 * PROG);
      read_chk(7'd3, {8'h00, model[3]}, "R4 write after lock ignored");
      frame(2'b11, 7'd4, 16'h0, 1'b0);
      end_frame();
      idle(2 * PROG);
      read_chk(7'd4, {8'h00, model[4]}, "R4 erase after lock ignored");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule